// File: doc/BRIEF.md
# Shared Enable/Status Interrupt Register

This block gathers a small group of interrupt sources behind a single 32-bit register. Each source has an enable bit in the lower half of the register and a sticky status bit in the upper half, sixteen positions above the enable bit. A qualifying event on a source input sets its status bit. The bit stays set until software writes a 1 to it. A write carrying 0 in a status position leaves that status bit alone. Software can therefore rewrite the enables freely without losing pending events.

The source field may start at a nonzero bit offset, so several instances can share one register layout or fill distinct slices of it. A parameter selects how a source input sets its status bit: on a rising edge, or on every cycle the input is high. One registered output tells a parent controller that at least one enabled source has its status bit set. This output is level-type: it stays high until every enabled status bit has been cleared or masked.

The register is reached over a plain register bus: address, write data and a write strobe, with combinational read data. The port is not a stream, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge that samples the strobe.

Top module: `irq_combo_reg`

## Requirements
- R1: Source i (0 <= i < NUM_SRC) has its enable bit at register bit BASE_BIT+i and its status bit at register bit BASE_BIT+i+16. A read at REG_ADDR returns both fields at these positions.
- R2: A write at REG_ADDR loads every enable bit of the field from the matching write-data bit. Enables change only on such a write.
- R3: Writing 1 to a status position clears that status bit. Writing 0 to a status position leaves that status bit unchanged.
- R4: In edge mode (EDGE_MODE=1), a status bit is set on the clock edge where its source is high after being low on the previous edge. A source held high does not set the bit again after the bit is cleared.
- R5: When a set event and a clearing write hit the same status bit on the same edge, the set wins and the bit ends set.
- R6: irq_o goes high one cycle after some source has both its status and enable bits set, and goes low one cycle after no such source remains. A status bit sets even when its enable is 0, but it does not drive irq_o.
- R7: Register bits outside the enable and status fields read as 0, and writes to them have no effect.
- R8: A write at any address other than REG_ADDR changes nothing. A read at any other address returns 0.
- R9: After reset all enable and status bits read 0 and irq_o is low.
- R10: With BASE_BIT=4 and NUM_SRC=2, the enables are bits 5:4 and the status bits are 21:20. Bits 3:0 and 7:6 are ignored.
- R11: In level mode (EDGE_MODE=0), a status bit is set on every edge where its source is high. A clearing write while the source stays high leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register bus address |
| wdata_i | input | 32 | Register bus write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| irq_o | output | 1 | Aggregated level interrupt to the parent |

## Verification
The assertions assume that src_i is already synchronous to clk and that the bus signals are stable around each rising edge. The bench meets this by changing every input only on the falling clock edge. The edge-detect checks also assume that the source history starts low at reset, so the bench holds all sources low through reset and releases them only after the reset state has been checked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Fixed register geometry: status bit sits this far above its enable bit.
  localparam int REG_W    = 32;
  localparam int STAT_OFS = 16;
  localparam int HALF_W   = 16;
endpackage

// File: rtl/irqc_src_detect.sv
module irqc_src_detect #(
  parameter int N    = 7,
  parameter bit EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] set_o
);
  generate
    if (EDGE) begin : g_edge
      logic [N-1:0] src_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
      end
      assign set_o = src_i & ~src_q;
    end else begin : g_lvl
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign set_o = src_i;
    end
  endgenerate
endmodule

// File: rtl/irqc_field_bank.sv
module irqc_field_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit_i,
  input  logic [N-1:0] en_wr_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (wr_hit_i) en_q <= en_wr_i;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   stat_q[i] <= 1'b0;
        else if (set_i[i])            stat_q[i] <= 1'b1;
        else if (wr_hit_i && clr_i[i]) stat_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign en_o   = en_q;
  assign stat_o = stat_q;

  // R4 R5 R11
  set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_i |=> $stable(en_q));
endmodule

// File: rtl/irqc_out_merge.sv
module irqc_out_merge #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] stat_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(en_i & stat_i);
  end

  assign irq_o = irq_q;

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past((en_i & stat_i) != '0));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i & stat_i) != '0) |=> irq_q);
endmodule

// File: rtl/irq_combo_reg.sv
module irq_combo_reg
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 7,
  parameter int          BASE_BIT  = 0,
  parameter bit          EDGE_MODE = 1'b1,
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               we_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int EN_LSB = BASE_BIT;
  localparam int ST_LSB = BASE_BIT + STAT_OFS;
  localparam logic [REG_W-1:0] FIELD_MASK =
    (((REG_W'(1) << NUM_SRC) - REG_W'(1)) << EN_LSB) |
    (((REG_W'(1) << NUM_SRC) - REG_W'(1)) << ST_LSB);

  initial begin
    if (NUM_SRC < 1 || BASE_BIT < 0 || BASE_BIT + NUM_SRC > HALF_W)
      $error("irq_combo_reg: source field does not fit in the lower half");
  end

  logic               sel;
  logic               wr_hit;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] stat_vec;
  logic               unused_wbits;

  assign sel          = (addr_i == REG_ADDR);
  assign wr_hit       = we_i && sel;
  assign unused_wbits = ^(wdata_i & ~FIELD_MASK);

  irqc_src_detect #(.N(NUM_SRC), .EDGE(EDGE_MODE)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .set_o (set_vec)
  );

  irqc_field_bank #(.N(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit_i (wr_hit),
    .en_wr_i  (wdata_i[EN_LSB +: NUM_SRC]),
    .clr_i    (wdata_i[ST_LSB +: NUM_SRC]),
    .set_i    (set_vec),
    .en_o     (en_vec),
    .stat_o   (stat_vec)
  );

  irqc_out_merge #(.N(NUM_SRC)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_vec),
    .stat_i (stat_vec),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      rdata_o[EN_LSB +: NUM_SRC] = en_vec;
      rdata_o[ST_LSB +: NUM_SRC] = stat_vec;
    end
  end

  // R7
  field_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~FIELD_MASK) == '0);

  // R8
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sel && set_vec == '0) |=> ($stable(en_vec) && $stable(stat_vec)));
endmodule

// File: tb/irq_combo_reg_bench.sv
module irq_combo_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr_a = '0, addr_b = '0;
  logic [31:0] wdata_a = '0, wdata_b = '0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic [6:0]  src_a = '0;
  logic [1:0]  src_b = '0;
  logic        irq_a, irq_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_combo_reg u_irq_combo_reg (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_a), .wdata_i(wdata_a), .we_i(we_a),
    .rdata_o(rdata_a), .src_i(src_a), .irq_o(irq_a)
  );

  irq_combo_reg #(.NUM_SRC(2), .BASE_BIT(4), .EDGE_MODE(1'b0)) u_irq_combo_reg_alt (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_b), .wdata_i(wdata_b), .we_i(we_b),
    .rdata_o(rdata_b), .src_i(src_b), .irq_o(irq_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    if (alt) begin addr_b = a; wdata_b = d; we_b = 1'b1; end
    else     begin addr_a = a; wdata_a = d; we_a = 1'b1; end
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0; addr_a = '0; addr_b = '0;
  endtask

  task automatic rd(input bit alt, input logic [3:0] a, output logic [31:0] d);
    if (alt) addr_b = a; else addr_a = a;
    #1;
    d = alt ? rdata_b : rdata_a;
    addr_a = '0; addr_b = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, 4'd0, d); check("R9 reg after reset", d, 32'h0);
    check("R9 irq after reset", {31'b0, irq_a}, 32'h0);
    rd(1'b1, 4'd0, d); check("R9 alt reg after reset", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(1'b0, 4'd0, 32'h0000_007F);
    rd(1'b0, 4'd0, d); check("R1 R2 all enables", d, 32'h0000_007F);
    wr(1'b0, 4'd0, 32'h0000_FF95);
    rd(1'b0, 4'd0, d); check("R7 upper enable bits ignored", d, 32'h0000_0015);
    wr(1'b0, 4'd3, 32'h0000_0000);
    rd(1'b0, 4'd0, d); check("R8 other-address write ignored", d, 32'h0000_0015);
    rd(1'b0, 4'd3, d); check("R8 other-address read zero", d, 32'h0);
    wr(1'b0, 4'd0, 32'h0000_0000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); src_a[2] = 1'b1;
    @(negedge clk);
    rd(1'b0, 4'd0, d); check("R4 R1 status set by edge", d, 32'h0004_0000);
    @(negedge clk);
    check("R6 masked source gives no irq", {31'b0, irq_a}, 32'h0);
    wr(1'b0, 4'd0, 32'h0000_0004);
    check("R6 irq not yet", {31'b0, irq_a}, 32'h0);
    @(negedge clk);
    check("R6 irq asserted", {31'b0, irq_a}, 32'h1);
    wr(1'b0, 4'd0, 32'h0004_0004);
    rd(1'b0, 4'd0, d); check("R4 R3 held-high source stays cleared", d, 32'h0000_0004);
    check("R6 irq still high one cycle", {31'b0, irq_a}, 32'h1);
    @(negedge clk);
    check("R6 irq deasserted", {31'b0, irq_a}, 32'h0);
    src_a[2] = 1'b0;
    wr(1'b0, 4'd0, 32'h0000_0000);
  endtask

  task automatic t_w0_keep();
    logic [31:0] d;
    @(negedge clk); src_a[0] = 1'b1; src_a[6] = 1'b1;
    @(negedge clk); src_a[0] = 1'b0; src_a[6] = 1'b0;
    wr(1'b0, 4'd0, 32'h0000_0041);
    rd(1'b0, 4'd0, d); check("R3 zero in status keeps it", d, 32'h0041_0041);
    wr(1'b0, 4'd0, 32'h0001_0041);
    rd(1'b0, 4'd0, d); check("R3 clear one status bit", d, 32'h0040_0041);
    check("R6 irq with remaining source", {31'b0, irq_a}, 32'h1);
    wr(1'b0, 4'd0, 32'hFF80_FF80);
    rd(1'b0, 4'd0, d); check("R7 R3 out-of-field write, clears", d, 32'h0040_0000);
    wr(1'b0, 4'd0, 32'h0040_0000);
    rd(1'b0, 4'd0, d); check("R3 final clear", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    addr_a = 4'd0; wdata_a = 32'h0002_0000; we_a = 1'b1; src_a[1] = 1'b1;
    @(negedge clk);
    we_a = 1'b0; src_a[1] = 1'b0;
    rd(1'b0, 4'd0, d); check("R5 set beats clear", d, 32'h0002_0000);
    wr(1'b0, 4'd0, 32'h0002_0000);
    rd(1'b0, 4'd0, d); check("R3 clear after collision", d, 32'h0);
  endtask

  task automatic t_alt();
    logic [31:0] d;
    wr(1'b1, 4'd0, 32'h0000_0030);
    rd(1'b1, 4'd0, d); check("R10 offset enables", d, 32'h0000_0030);
    wr(1'b1, 4'd0, 32'h0000_00DF);
    rd(1'b1, 4'd0, d); check("R10 bits outside 5:4 ignored", d, 32'h0000_0010);
    wr(1'b1, 4'd0, 32'h0000_0030);
    @(negedge clk); src_b[1] = 1'b1;
    @(negedge clk);
    rd(1'b1, 4'd0, d); check("R10 R11 status at bit 21", d, 32'h0020_0030);
    @(negedge clk);
    check("R6 alt irq", {31'b0, irq_b}, 32'h1);
    wr(1'b1, 4'd0, 32'h0020_0030);
    rd(1'b1, 4'd0, d); check("R11 level source re-sets", d, 32'h0020_0030);
    src_b[1] = 1'b0;
    wr(1'b1, 4'd0, 32'h0020_0030);
    rd(1'b1, 4'd0, d); check("R11 clear after release", d, 32'h0000_0030);
    @(negedge clk);
    check("R6 alt irq low", {31'b0, irq_b}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_edge();
    t_w0_keep();
    t_set_wins();
    t_alt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule